// File: doc/BRIEF.md
# Event Ring Producer with Inverted Index Convention

This block sits on the device side of a host-to-device link and posts completion and state-change events into an event ring in host memory. The device produces at the read index and the host frees slots by advancing the write index. So the ring is full when the two indices are equal and empty when the write index plus one equals the read index. This is the reverse of the test a transfer ring uses.

An upstream agent presents a ready-made event on a valid/ready handshake. For each event the block accepts, it does three things in order:
- It issues one memory write at `base + read_index * ELEM_BYTES`.
- It advances the read index, modulo the ring length, when the memory side accepts the write.
- It pulses an interrupt in the next cycle.

The host hands slots back by writing a new write index through a doorbell input. The block keeps its own copies of both indices. Only one element write is outstanding at a time.

Top module: `evring_producer`

## Requirements
- R1: After reset the read index is 0, the write index is RING_LEN-1 and the ring is empty. `evt_ready` is 1, and `wr_valid` and `irq` are 0.
- R2: The write request for an accepted event carries the address `cfg_base + read_index * ELEM_BYTES`. With ELEM_BYTES=16 and a base of 0x80001000, the first event after reset goes to 0x80001000.
- R3: `wr_data` equals the accepted `evt_data`. `wr_addr`, `wr_data` and `wr_valid` hold steady for as long as `wr_ready` stays low.
- R4: The read index advances by exactly one on each completed write handshake (`wr_valid && wr_ready`) and stays put otherwise. It wraps from RING_LEN-1 to 0, including when RING_LEN is not a power of two.
- R5: `irq` is high for exactly one cycle: the cycle after each write handshake, and at no other time.
- R6: While the read index equals the write index (ring full), `evt_ready` is 0 and a presented event starts no write. From reset, exactly RING_LEN-1 events fit before the ring is full.
- R7: A doorbell write (`db_we` high) with `db_idx < RING_LEN` replaces the write index. Freed slots show up as `evt_ready` high in the next cycle.
- R8: A doorbell write with `db_idx >= RING_LEN` is ignored, and the write index is unchanged.
- R9: While a write is outstanding (`wr_valid` high), `evt_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Ring base address, held stable by the host |
| evt_valid | input | 1 | Event request valid |
| evt_ready | output | 1 | Event request can be accepted |
| evt_data | input | DATA_W | Event element payload |
| wr_valid | output | 1 | Element write request valid |
| wr_ready | input | 1 | Memory side accepts the write |
| wr_addr | output | ADDR_W | Element write address |
| wr_data | output | DATA_W | Element write payload |
| db_we | input | 1 | Event doorbell write strobe |
| db_idx | input | $clog2(RING_LEN)+1 | New write index from the host |
| irq | output | 1 | One-cycle interrupt pulse per posted event |

## Verification
The assertions check on every cycle that:
- the read index never leaves its range and moves only on a write handshake;
- no write completes while the ring is full;
- the outstanding write holds steady under back-pressure;
- `irq` is a single-cycle pulse that follows a handshake;
- an out-of-range doorbell leaves the write index alone.

Some behaviours only the bench's scenarios can show:
- the exact addresses across a wrap of a six-entry ring;
- that exactly five events fill the ring from reset;
- that a doorbell frees slots that the next events then use.

// File: rtl/evr_pkg.sv
package evr_pkg;
   typedef enum logic {
      EVR_IDLE  = 1'b0,
      EVR_WRITE = 1'b1
   } evr_state_e;
endpackage

// File: rtl/evr_index_ctrl.sv
module evr_index_ctrl #(
   parameter int RING_LEN = 6,
   parameter int IDX_W    = $clog2(RING_LEN),
   parameter int DB_W     = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             db_we,
   input  logic [DB_W-1:0]  db_idx,
   output logic [IDX_W-1:0] rd_idx,
   output logic             ring_full
);
   localparam bit IS_POW2 = (RING_LEN & (RING_LEN - 1)) == 0;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);
   localparam logic [DB_W-1:0]  LEN_DB   = DB_W'(RING_LEN);

   logic [IDX_W-1:0] rd_q;
   logic [IDX_W-1:0] wr_q;
   logic [IDX_W-1:0] rd_nxt;
   logic             db_ok;

   generate
      if (IS_POW2) begin : g_wrap_natural
         assign rd_nxt = rd_q + IDX_W'(1);
      end else begin : g_wrap_compare
         assign rd_nxt = (rd_q == LAST_IDX) ? '0 : rd_q + IDX_W'(1);
      end
   endgenerate

   assign db_ok = db_we && (db_idx < LEN_DB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (advance) begin
         rd_q <= rd_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= LAST_IDX;
      end else if (db_ok) begin
         wr_q <= db_idx[IDX_W-1:0];
      end
   end

   assign rd_idx    = rd_q;
   assign ring_full = (rd_q == wr_q);

   AST_RD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, rd_q} < LEN_DB)); // R4
   AST_RD_MOVES_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(rd_q)); // R4
   AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> !ring_full); // R6
   AST_BAD_DOORBELL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (db_we && (db_idx >= LEN_DB)) |=> $stable(wr_q)); // R8
endmodule

// File: rtl/evr_addr_gen.sv
module evr_addr_gen #(
   parameter int ADDR_W     = 32,
   parameter int IDX_W      = 3,
   parameter int ELEM_BYTES = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   localparam bit ELEM_POW2  = (ELEM_BYTES & (ELEM_BYTES - 1)) == 0;
   localparam int ELEM_SHIFT = $clog2(ELEM_BYTES);

   logic [ADDR_W-1:0] offset;

   generate
      if (ELEM_POW2) begin : g_off_shift
         assign offset = ADDR_W'(idx) << ELEM_SHIFT;
      end else begin : g_off_mult
         assign offset = ADDR_W'(idx) * ADDR_W'(ELEM_BYTES);
      end
   endgenerate

   assign addr = base + offset;
endmodule

// File: rtl/evr_post_fsm.sv
module evr_post_fsm
   import evr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   output logic              evt_ready,
   input  logic [DATA_W-1:0] evt_data,
   input  logic              ring_full,
   input  logic [ADDR_W-1:0] slot_addr,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              advance,
   output logic              irq
);
   evr_state_e        st_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              irq_q;
   logic              take;

   assign evt_ready = (st_q == EVR_IDLE) && !ring_full;
   assign take      = evt_valid && evt_ready;
   assign wr_valid  = (st_q == EVR_WRITE);
   assign advance   = wr_valid && wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= EVR_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         case (st_q)
            EVR_IDLE: begin
               if (take) begin
                  st_q   <= EVR_WRITE;
                  addr_q <= slot_addr;
                  data_q <= evt_data;
               end
            end
            EVR_WRITE: begin
               if (wr_ready) begin
                  st_q <= EVR_IDLE;
               end
            end
            default: st_q <= EVR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= advance;
      end
   end

   assign wr_addr = addr_q;
   assign wr_data = data_q;
   assign irq     = irq_q;

   AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R3
   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R5
   AST_IRQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wr_valid && wr_ready)); // R5
   AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !evt_ready); // R9
endmodule

// File: rtl/evring_producer.sv
module evring_producer #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int RING_LEN   = 6,
   parameter int ELEM_BYTES = 16,
   localparam int IDX_W     = $clog2(RING_LEN),
   localparam int DB_W      = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic              evt_valid,
   output logic              evt_ready,
   input  logic [DATA_W-1:0] evt_data,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   input  logic              db_we,
   input  logic [DB_W-1:0]   db_idx,
   output logic              irq
);
   generate
      if (RING_LEN < 2) begin : g_bad_len
         $error("evring_producer: RING_LEN must be at least 2");
      end
      if (ELEM_BYTES < 1) begin : g_bad_elem
         $error("evring_producer: ELEM_BYTES must be at least 1");
      end
      if (DATA_W < 1 || ADDR_W < 2) begin : g_bad_width
         $error("evring_producer: DATA_W and ADDR_W are too small");
      end
   endgenerate

   logic [IDX_W-1:0]  rd_idx;
   logic              ring_full;
   logic              advance;
   logic [ADDR_W-1:0] slot_addr;

   evr_index_ctrl #(
      .RING_LEN (RING_LEN),
      .IDX_W    (IDX_W),
      .DB_W     (DB_W)
   ) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .db_we     (db_we),
      .db_idx    (db_idx),
      .rd_idx    (rd_idx),
      .ring_full (ring_full)
   );

   evr_addr_gen #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .ELEM_BYTES (ELEM_BYTES)
   ) u_addr (
      .base (cfg_base),
      .idx  (rd_idx),
      .addr (slot_addr)
   );

   evr_post_fsm #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_valid (evt_valid),
      .evt_ready (evt_ready),
      .evt_data  (evt_data),
      .ring_full (ring_full),
      .slot_addr (slot_addr),
      .wr_valid  (wr_valid),
      .wr_ready  (wr_ready),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .advance   (advance),
      .irq       (irq)
   );
endmodule

// File: tb/sim_evring_producer.sv
`timescale 1ns/1ps
module sim_evring_producer;
   localparam int ADDR_W   = 32;
   localparam int DATA_W   = 64;
   localparam int RING_LEN = 6;
   localparam int ELEM_B   = 16;
   localparam int DB_W     = $clog2(RING_LEN) + 1;
   localparam logic [ADDR_W-1:0] BASE = 32'h8000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              evt_valid = 1'b0;
   logic              evt_ready;
   logic [DATA_W-1:0] evt_data = '0;
   logic              wr_valid;
   logic              wr_ready = 1'b0;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              db_we = 1'b0;
   logic [DB_W-1:0]   db_idx = '0;
   logic              irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   evring_producer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RING_LEN(RING_LEN), .ELEM_BYTES(ELEM_B)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_base(BASE),
      .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_data(evt_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .db_we(db_we), .db_idx(db_idx), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] slot(input int idx);
      return 64'(BASE + ADDR_W'(idx * ELEM_B));
   endfunction

   task automatic t_reset();
      check("R1 evt_ready after reset", 64'(evt_ready), 64'd1);
      check("R1 wr_valid after reset", 64'(wr_valid), 64'd0);
      check("R1 irq after reset", 64'(irq), 64'd0);
   endtask

   // One event, optional memory stall, address/data/irq checked (R2 R3 R4 R5 R9)
   task automatic t_post(input logic [63:0] d, input int stall, input int exp_idx);
      @(negedge clk);
      check("R6 ready before post", 64'(evt_ready), 64'd1);
      evt_valid = 1'b1;
      evt_data  = d;
      @(negedge clk);
      evt_valid = 1'b0;
      check("R3 wr_valid raised", 64'(wr_valid), 64'd1);
      check("R2 R4 write address", 64'(wr_addr), slot(exp_idx));
      check("R3 write payload", wr_data, d);
      check("R9 ready low while outstanding", 64'(evt_ready), 64'd0);
      for (int i = 0; i < stall; i++) begin
         @(negedge clk);
         check("R3 valid held in stall", 64'(wr_valid), 64'd1);
         check("R3 address held in stall", 64'(wr_addr), slot(exp_idx));
         check("R3 payload held in stall", wr_data, d);
         check("R5 no irq during stall", 64'(irq), 64'd0);
      end
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
      check("R5 irq after handshake", 64'(irq), 64'd1);
      check("R3 wr_valid dropped", 64'(wr_valid), 64'd0);
      @(negedge clk);
      check("R5 irq single cycle", 64'(irq), 64'd0);
   endtask

   task automatic t_blocked(input string req);
      @(negedge clk);
      evt_valid = 1'b1;
      evt_data  = 64'hDEAD_0000_0000_BEEF;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check({req, " ready low when full"}, 64'(evt_ready), 64'd0);
         check({req, " no write when full"}, 64'(wr_valid), 64'd0);
      end
      evt_valid = 1'b0;
   endtask

   task automatic t_doorbell(input logic [DB_W-1:0] v);
      @(negedge clk);
      db_we  = 1'b1;
      db_idx = v;
      @(negedge clk);
      db_we  = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      // R2 first slot at base, R4 sequence 0..4 fills five slots
      t_post(64'h1111_0000_0000_0001, 0, 0);
      t_post(64'h2222_0000_0000_0002, 3, 1);
      t_post(64'h3333_0000_0000_0003, 0, 2);
      t_post(64'h4444_0000_0000_0004, 1, 3);
      t_post(64'h5555_0000_0000_0005, 0, 4);
      t_blocked("R6");
      // R8 out-of-range doorbell values leave the ring full
      t_doorbell(DB_W'(7));
      t_blocked("R8 idx7");
      t_doorbell(DB_W'(6));
      t_blocked("R8 idx6");
      // R7 doorbell frees slots, visible on the next cycle
      t_doorbell(DB_W'(2));
      check("R7 ready after doorbell", 64'(evt_ready), 64'd1);
      t_post(64'h6666_0000_0000_0006, 0, 5);
      t_post(64'h7777_0000_0000_0007, 2, 0); // R4 wrap 5 -> 0
      t_post(64'h8888_0000_0000_0008, 0, 1);
      t_blocked("R6 after wrap");
      t_doorbell(DB_W'(1));
      check("R7 ready after second doorbell", 64'(evt_ready), 64'd1);
      t_post(64'h9999_0000_0000_0009, 0, 2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule